// File: doc/BRIEF.md
# Prioritised Vectoring Interrupt Controller

The block collects thirteen level-sensitive peripheral request lines, numbered 1 to 13, and presents one interrupt to the processor as a 3-bit level and an 8-bit vector. It holds three kinds of state. A pending register follows the request lines. A mask register blocks sources. Each source has one control byte that carries a 5-bit arbitration key and an autovector select bit.

Among the sources that are pending and not masked, the one with the largest key wins. A key of level 0 presents nothing. The vector is either computed from the level, or it is read from one of three programmable vector registers that belong to particular sources. Software reaches all of this state through a byte-wide register port with a combinational read path. Acknowledge handling is not part of the block.

Top module: `irq_prio_vec`

## Requirements
- R1: After reset, irq_level and irq_vector are 0. The mask reads 0x3F at offset 0x36 (mask bits 15:8) and 0xFE at offset 0x37 (mask bits 7:0). Control bytes for sources 1..13 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00, 0x00. The vector register at 0x42 reads 0x0F.
- R2: Bit k of the pending register equals request line k (req[k]), one clock after the line changes. The register reads at 0x3A (bits 15:8) and 0x3B (bits 7:0). Bits 0, 14 and 15 read 0.
- R3: Mask bit k set to 1 excludes source k from arbitration. The mask is written through 0x36 and 0x37.
- R4: The control byte of source k sits at offset 0x13+k. Bits 4:0 form the arbitration key, bits 4:2 give the interrupt level, and bit 7 selects autovector.
- R5: The active source with the strictly largest key wins. When two sources have equal keys, the lower-numbered source wins.
- R6: If the winning key is below 4, or no source is active, level and vector are both 0.
- R7: If the winner's autovector bit is set, the vector is 24 plus the level.
- R8: Without autovector, the vector depends on the winning source. Source 8 uses the register at 0x42, source 12 uses the register at 0x170, and source 13 uses the register at 0x1B0. Any other source gives 0x0F.
- R9: Writes to 0x3A and 0x3B change neither the pending register nor the outputs.
- R10: irq_level and irq_vector change on the first clock edge after the edge that updated the pending, mask or control state.
- R11: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 13 | Request lines, bit k is source k |
| reg_we | input | 1 | Byte write strobe |
| reg_addr | input | 9 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq_level | output | 3 | Presented interrupt level, 0 means none |
| irq_vector | output | 8 | Presented interrupt vector |

## Verification
The bench builds the block with its default parameters: thirteen sources, a 9-bit offset, and the special vector sources at 8, 12 and 13. These defaults place every register decode and every vector path within reach of directed writes. They include the tie between sources 7 and 8, whose reset keys are equal, and the cutoff on source 1, whose reset key sits exactly on the boundary.

// File: rtl/irq_prio_vec.sv
module irq_prio_vec #(
  parameter int NSRC      = 13,
  parameter int ADDR_W    = 9,
  parameter int KEY_W     = 5,
  parameter int WDOG_SRC  = 8,
  parameter int UART0_SRC = 12,
  parameter int UART1_SRC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [2:0]        irq_level,
  output logic [7:0]        irq_vector
);
  localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(9'h013);
  localparam logic [ADDR_W-1:0] A_MSKH  = ADDR_W'(9'h036);
  localparam logic [ADDR_W-1:0] A_MSKL  = ADDR_W'(9'h037);
  localparam logic [ADDR_W-1:0] A_PNDH  = ADDR_W'(9'h03A);
  localparam logic [ADDR_W-1:0] A_PNDL  = ADDR_W'(9'h03B);
  localparam logic [ADDR_W-1:0] A_WDV   = ADDR_W'(9'h042);
  localparam logic [ADDR_W-1:0] A_UV0   = ADDR_W'(9'h170);
  localparam logic [ADDR_W-1:0] A_UV1   = ADDR_W'(9'h1B0);
  localparam logic [KEY_W-1:0]  MIN_KEY = KEY_W'(4);

  function automatic logic [7:0] ctrl_init(int k);
    if (k <= 7)       return 8'(k * 4);
    else if (k == 8)  return 8'h1C;
    else if (k <= 11) return 8'h80;
    else              return 8'h00;
  endfunction

  logic [NSRC:1] pend;
  logic [15:0]   mask_q;
  logic [7:0]    ctrl [1:NSRC];
  logic [7:0]    wdv, uv0, uv1;
  logic [15:0]   pend16;

  assign pend16 = 16'({pend, 1'b0});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      mask_q <= 16'h3FFE;
      wdv    <= 8'h0F;
      uv0    <= 8'h00;
      uv1    <= 8'h00;
      for (int i = 1; i <= NSRC; i++) ctrl[i] <= ctrl_init(i);
    end else begin
      pend <= req;
      if (reg_we) begin
        case (reg_addr)
          A_MSKH: mask_q[15:8] <= reg_wdata;
          A_MSKL: mask_q[7:0]  <= reg_wdata;
          A_WDV:  wdv          <= reg_wdata;
          A_UV0:  uv0          <= reg_wdata;
          A_UV1:  uv1          <= reg_wdata;
          default: ;
        endcase
        for (int i = 1; i <= NSRC; i++)
          if (reg_addr == A_CTRL0 + ADDR_W'(i)) ctrl[i] <= reg_wdata;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_MSKH:  reg_rdata = mask_q[15:8];
      A_MSKL:  reg_rdata = mask_q[7:0];
      A_PNDH:  reg_rdata = pend16[15:8];
      A_PNDL:  reg_rdata = pend16[7:0];
      A_WDV:   reg_rdata = wdv;
      A_UV0:   reg_rdata = uv0;
      A_UV1:   reg_rdata = uv1;
      default: reg_rdata = 8'h00;
    endcase
    for (int i = 1; i <= NSRC; i++)
      if (reg_addr == A_CTRL0 + ADDR_W'(i)) reg_rdata = ctrl[i];
  end

  logic [KEY_W-1:0] best_key;
  logic [7:0]       best_ctrl;
  int               best_src;
  logic [2:0]       lvl_d;
  logic [7:0]       vec_d;

  always_comb begin
    best_key  = '0;
    best_ctrl = '0;
    best_src  = 0;
    for (int i = 1; i <= NSRC; i++)
      if (pend[i] && !mask_q[i] && ctrl[i][KEY_W-1:0] > best_key) begin
        best_key  = ctrl[i][KEY_W-1:0];
        best_ctrl = ctrl[i];
        best_src  = i;
      end
    lvl_d = 3'd0;
    vec_d = 8'h00;
    if (best_key >= MIN_KEY) begin
      lvl_d = best_ctrl[4:2];
      if (best_ctrl[7])                vec_d = 8'd24 + {5'd0, lvl_d};
      else if (best_src == WDOG_SRC)   vec_d = wdv;
      else if (best_src == UART0_SRC)  vec_d = uv0;
      else if (best_src == UART1_SRC)  vec_d = uv1;
      else                             vec_d = 8'h0F;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_level  <= 3'd0;
      irq_vector <= 8'h00;
    end else begin
      irq_level  <= lvl_d;
      irq_vector <= vec_d;
    end
  end

  // R6
  no_level_no_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == 3'd0 |-> irq_vector == 8'h00);

  // R3
  all_blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~mask_q[NSRC:1]) == '0 |=> irq_level == 3'd0);

  // R10
  level_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != 3'd0 |-> $past((pend & ~mask_q[NSRC:1]) != '0));

  // R9
  pend_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == A_PNDH || reg_addr == A_PNDL) |=> $stable(mask_q));

  // R7
  autovec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != 3'd0 && $past(best_ctrl[7]) |-> irq_vector == 8'd24 + {5'd0, irq_level});
endmodule

// File: tb/irq_prio_vec_tb.sv
module irq_prio_vec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:1] req = '0;
  logic        reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_prio_vec dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_level(irq_level),
    .irq_vector(irq_vector));

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 9'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(string tag, int a, int exp);
    reg_addr = 9'(a);
    #1;
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic out(string tag, int lvl, int vec);
    check({tag, " level"}, int'(irq_level), lvl);
    check({tag, " vector"}, int'(irq_vector), vec);
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  task automatic t_reset;
    out("R1 reset", 0, 0);
    rd("R1 mask hi", 'h36, 'h3F);
    rd("R1 mask lo", 'h37, 'hFE);
    for (int k = 1; k <= 13; k++)
      rd("R1 R4 ctrl reset", 'h13 + k, (k <= 7) ? k * 4 : (k == 8) ? 'h1C : (k <= 11) ? 'h80 : 0);
    rd("R1 wdog vec", 'h42, 'h0F);
    rd("R11 unmapped", 'h50, 0);
  endtask

  task automatic t_masked;
    @(negedge clk); req = '1;
    settle(); settle();
    rd("R2 pend hi", 'h3A, 'h3F);
    rd("R2 pend lo", 'h3B, 'hFE);
    out("R3 all masked", 0, 0);
  endtask

  task automatic t_latency;
    wr('h37, 'hDE);
    out("R10 before update", 0, 0);
    settle();
    out("R3 R8 src5 other vec", 5, 'h0F);
  endtask

  task automatic t_priority;
    wr('h37, 'h56); settle();
    out("R5 src7 beats 3 and 5", 7, 'h0F);
    wr('h36, 'h3E); wr('h37, 'h7E); settle();
    out("R5 tie lower index", 7, 'h0F);
    wr('h1B, 'h1D); settle();
    out("R5 R8 src8 larger key wdog", 7, 'h0F);
    wr('h42, 'h55); settle();
    out("R8 wdog vec reg", 7, 'h55);
  endtask

  task automatic t_auto;
    wr('h36, 'h3D); wr('h37, 'hFE); wr('h1C, 'h98); settle();
    out("R7 autovector", 6, 30);
  endtask

  task automatic t_cutoff;
    wr('h36, 'h3F); wr('h37, 'hFC); settle();
    out("R6 key4 passes", 1, 'h0F);
    wr('h14, 'h03); settle();
    out("R6 key3 cut", 0, 0);
  endtask

  task automatic t_uart;
    wr('h36, 'h2F); wr('h37, 'hFE); wr('h170, 'h40); wr('h1F, 'h10); settle();
    out("R8 uart0 vec", 4, 'h40);
    wr('h36, 'h0F); wr('h1B0, 'h41); wr('h20, 'h14); settle();
    out("R8 uart1 vec", 5, 'h41);
  endtask

  task automatic t_pend_ro;
    wr('h3A, 'h00); wr('h3B, 'h00); settle();
    rd("R9 pend hi kept", 'h3A, 'h3F);
    rd("R9 pend lo kept", 'h3B, 'hFE);
    out("R9 output kept", 5, 'h41);
  endtask

  task automatic t_track;
    @(negedge clk); req[13] = 1'b0;
    settle(); settle();
    rd("R2 pend hi drop", 'h3A, 'h1F);
    out("R2 falls back to src12", 4, 'h40);
    @(negedge clk); req = '0;
    settle(); settle();
    out("R2 none pending", 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_masked();
    t_latency();
    t_priority();
    t_auto();
    t_cutoff();
    t_uart();
    t_pend_ro();
    t_track();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule